// File: doc/BRIEF.md
# Repetition-gated timer time base

This block is the time base of a general-purpose timer. A prescaler divides the clock into count ticks, and a counter steps on each tick up to an auto-reload limit, down from it, or up and back down in center-aligned fashion. Each overflow or underflow is a wrap. A repetition down-counter stands between the wraps and the update event. The update event is raised only when that counter is already at zero as a wrap arrives. At that point the counter reloads itself from its repetition register, so the update recurs once every (repetition value + 1) wraps.

Every update event copies the preload values for the prescaler, the auto-reload limit and the compare registers into the active copies. It also raises a sticky update flag. Software can force an update at once by writing the event register, and so can a trigger pulse from outside the block. A forced update ignores the repetition count. It reloads the repetition counter and restarts the prescaler and the counter. Register access is through a single write port. The outputs are a one-cycle update pulse, the update flag, the counter value and the active compare values.

Top module: `rep_gated_timebase`

## Requirements
- R1: After reset the counter value, the update pulse, the update flag and every active compare value are 0. The preload and active limits are 0xFFFF, and the prescaler and repetition values are 0.
- R2: Register addresses: 0 control, 1 event, 2 status, 3 prescaler preload, 4 limit preload, 5 repetition, 6+i compare i preload. With prescaler value P, a running counter (control bit 0 = 1) steps once every P+1 clocks, and the prescaler restarts from zero on every forced update.
- R3: The counting mode is control bits [2:1]. In up mode (0) the counter runs 0..L and a tick at L or above gives an overflow back to 0. In down mode (1) it runs L..0 and a tick at 0 gives an underflow and reloads the limit that is active after that edge.
- R4: In center mode (2, and 3 acts the same) the counter rises to L. The next tick is an overflow that turns it down to L-1. It falls to 0, and the next tick is an underflow that turns it up to 1. With L = 0 it stays at 0.
- R5: A wrap raises the update event only when the repetition counter is zero. With repetition value N and no writes, updates come exactly once every N+1 wraps.
- R6: The repetition counter decrements on overflows in up mode and on underflows in down mode. In center mode it decrements on both, so N = 1 with limit L gives one update every 2L clocks at P = 0.
- R7: On every update event the prescaler, limit (when preloaded) and compare preload values become active. Between updates, a preload write leaves the active compare values unchanged.
- R8: With control bit 3 set, a limit write goes only to the preload register and the running period still ends at the old limit. With bit 3 clear, the write takes effect on the running count at once.
- R9: Writing 1 to event bit 0, or a high slave_trig, gives an update pulse in the next cycle whatever the repetition count. It reloads the repetition counter and restarts the counter at 0, or at the new limit in down mode. The event write stores nothing.
- R10: The update flag rises in the same cycle as the update pulse and stays high. A status write with bit 0 = 0 clears it, a status write with bit 0 = 1 does nothing, and an update in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Register address |
| wr_data | input | DATA_W (16) | Register write data |
| slave_trig | input | 1 | External trigger that forces an update |
| upd_evt | output | 1 | One-cycle update event pulse |
| upd_flag | output | 1 | Sticky update interrupt flag |
| cnt_val | output | CNT_W (16) | Counter value |
| cmp_act | output | NUM_CMP*CNT_W (32) | Active compare values, compare i at bits [i*CNT_W +: CNT_W] |

## Verification
The repetition gate is run in each counting mode with a different repetition value: up with N = 2, down with N = 0 and center with N = 1. Counting the update pulses over a fixed window separates the three decrement sources, because the center mode's double-rate decrement gives a count that neither single-edge mode would. A prescaler value of 2, a mid-period limit write with and without preload, a compare write followed by a forced update, and a flag clear that collides with a trigger each isolate one rule. A long stretch of random writes and triggers is compared cycle by cycle against a behavioural model of the whole time base. That stretch reaches mode changes in mid-count, zero limits and collisions between updates and writes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_UP     = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_CENTER = 2'd2
  } cnt_mode_e;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_EVT  = 1;
  localparam int ADDR_STAT = 2;
  localparam int ADDR_PSC  = 3;
  localparam int ADDR_ARR  = 4;
  localparam int ADDR_REP  = 5;
  localparam int ADDR_CMP0 = 6;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MODE_LSB = 1;
  localparam int CTRL_ARPE_BIT = 3;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [PSC_W-1:0] psc_lim,
  output logic             tick
);

  localparam logic [PSC_W-1:0] ONE = PSC_W'(1);

  logic [PSC_W-1:0] div_q, div_d;

  always_comb begin
    tick  = en && (div_q >= psc_lim);
    div_d = div_q;
    if (restart)  div_d = '0;
    else if (en)  div_d = tick ? '0 : div_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R2: a restart always returns the divider to zero
  a_r2_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (div_q == '0));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] arr_act,
  input  logic [CNT_W-1:0] arr_next,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             unf
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dn_q, dn_d;

  always_comb begin
    cnt_d = cnt_q;
    dn_d  = dn_q;
    ovf   = 1'b0;
    unf   = 1'b0;
    if (load) begin
      cnt_d = (mode == MODE_DOWN) ? arr_next : '0;
      dn_d  = 1'b0;
    end else if (tick) begin
      case (mode)
        MODE_UP: begin
          dn_d = 1'b0;
          if (cnt_q >= arr_act) begin
            ovf   = 1'b1;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        MODE_DOWN: begin
          dn_d = 1'b0;
          if (cnt_q == '0) begin
            unf   = 1'b1;
            cnt_d = arr_next;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        default: begin
          if (!dn_q) begin
            if (cnt_q >= arr_act) begin
              ovf   = 1'b1;
              dn_d  = 1'b1;
              cnt_d = (arr_act == '0) ? '0 : arr_act - ONE;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else begin
            if (cnt_q == '0) begin
              unf   = 1'b1;
              dn_d  = 1'b0;
              cnt_d = (arr_act == '0) ? '0 : ONE;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end

  assign cnt = cnt_q;

  // R3: an up-mode tick below the limit advances by exactly one
  a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && mode == MODE_UP && cnt_q < arr_act) |=> (cnt_q == $past(cnt_q) + ONE));

  // R4: a center-mode overflow turns the count downward
  a_r4_center_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && mode == MODE_CENTER && arr_act != '0) |=> (cnt_q < $past(cnt_q)));

  // R9: a forced restart in up mode lands on zero
  a_r9_restart_up: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mode == MODE_UP) |=> (cnt_q == '0));

endmodule

// File: rtl/tmr_rep_gate.sv
module tmr_rep_gate #(
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic             force_upd,
  input  logic [REP_W-1:0] rep_val,
  output logic             upd
);

  localparam logic [REP_W-1:0] ONE = REP_W'(1);

  logic [REP_W-1:0] rep_q, rep_d;
  logic             expire;

  always_comb begin
    expire = wrap && (rep_q == '0);
    upd    = force_upd || expire;
    rep_d  = rep_q;
    if (upd)       rep_d = rep_val;
    else if (wrap) rep_d = rep_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rep_q <= '0;
    else        rep_q <= rep_d;
  end

  // R6: a wrap with repetitions left counts down by one
  a_r6_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !force_upd && rep_q != '0) |=> (rep_q == $past(rep_q) - ONE));

  // R9: a forced update reloads the repetition counter
  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> (rep_q == $past(rep_val)));

  // R5: no update without a wrap or a force
  a_r5_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !force_upd) |-> !upd);

endmodule

// File: rtl/rep_gated_timebase.sv
module rep_gated_timebase
  import tmr_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 16,
  parameter int PSC_W   = 16,
  parameter int REP_W   = 8,
  parameter int NUM_CMP = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     slave_trig,
  output logic                     upd_evt,
  output logic                     upd_flag,
  output logic [CNT_W-1:0]         cnt_val,
  output logic [NUM_CMP*CNT_W-1:0] cmp_act
);

  localparam logic [CNT_W-1:0] ARR_RST = {CNT_W{1'b1}};

  // control and preload state
  logic             en_q, en_d;
  logic [1:0]       mode_q, mode_d;
  logic             arpe_q, arpe_d;
  logic [PSC_W-1:0] psc_pre_q, psc_pre_d, psc_act_q, psc_act_d;
  logic [CNT_W-1:0] arr_pre_q, arr_pre_d, arr_act_q, arr_next;
  logic [REP_W-1:0] rep_q, rep_d;
  logic             evt_q, flag_q, flag_d;

  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_pre_q, cmp_act_q;

  // write decode
  logic wr_ctrl, wr_evt, wr_stat, wr_psc, wr_arr, wr_rep;
  logic force_upd, tick, ovf, unf, upd;
  cnt_mode_e mode;

  always_comb begin
    wr_ctrl = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
    wr_evt  = wr_en && (wr_addr == ADDR_W'(ADDR_EVT));
    wr_stat = wr_en && (wr_addr == ADDR_W'(ADDR_STAT));
    wr_psc  = wr_en && (wr_addr == ADDR_W'(ADDR_PSC));
    wr_arr  = wr_en && (wr_addr == ADDR_W'(ADDR_ARR));
    wr_rep  = wr_en && (wr_addr == ADDR_W'(ADDR_REP));
    force_upd = (wr_evt && wr_data[0]) || slave_trig;
    mode = (mode_q == 2'd3) ? MODE_CENTER : cnt_mode_e'(mode_q);
  end

  // next-state for control, preloads and active copies
  always_comb begin
    en_d      = en_q;
    mode_d    = mode_q;
    arpe_d    = arpe_q;
    psc_pre_d = psc_pre_q;
    arr_pre_d = arr_pre_q;
    rep_d     = rep_q;
    if (wr_ctrl) begin
      en_d   = wr_data[CTRL_EN_BIT];
      mode_d = wr_data[CTRL_MODE_LSB +: 2];
      arpe_d = wr_data[CTRL_ARPE_BIT];
    end
    if (wr_psc) psc_pre_d = wr_data[PSC_W-1:0];
    if (wr_arr) arr_pre_d = wr_data[CNT_W-1:0];
    if (wr_rep) rep_d     = wr_data[REP_W-1:0];

    psc_act_d = upd ? psc_pre_q : psc_act_q;
    if (wr_arr && !arpe_q) arr_next = wr_data[CNT_W-1:0];
    else if (upd)          arr_next = arr_pre_q;
    else                   arr_next = arr_act_q;

    flag_d = flag_q;
    if (upd)                      flag_d = 1'b1;
    else if (wr_stat && !wr_data[0]) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      mode_q    <= 2'd0;
      arpe_q    <= 1'b0;
      psc_pre_q <= '0;
      psc_act_q <= '0;
      arr_pre_q <= ARR_RST;
      arr_act_q <= ARR_RST;
      rep_q     <= '0;
      evt_q     <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      en_q      <= en_d;
      mode_q    <= mode_d;
      arpe_q    <= arpe_d;
      psc_pre_q <= psc_pre_d;
      psc_act_q <= psc_act_d;
      arr_pre_q <= arr_pre_d;
      arr_act_q <= arr_next;
      rep_q     <= rep_d;
      evt_q     <= upd;
      flag_q    <= flag_d;
    end
  end

  // compare preload and shadow pairs
  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
    logic wr_cmp;
    logic [CNT_W-1:0] pre_d, act_d;
    always_comb begin
      wr_cmp = wr_en && (wr_addr == ADDR_W'(ADDR_CMP0 + gi));
      pre_d  = wr_cmp ? wr_data[CNT_W-1:0] : cmp_pre_q[gi];
      act_d  = upd ? cmp_pre_q[gi] : cmp_act_q[gi];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_pre_q[gi] <= '0;
        cmp_act_q[gi] <= '0;
      end else begin
        cmp_pre_q[gi] <= pre_d;
        cmp_act_q[gi] <= act_d;
      end
    end
  end

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en_q),
    .restart (force_upd),
    .psc_lim (psc_act_q),
    .tick    (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (force_upd),
    .mode     (mode),
    .arr_act  (arr_act_q),
    .arr_next (arr_next),
    .cnt      (cnt_val),
    .ovf      (ovf),
    .unf      (unf)
  );

  tmr_rep_gate #(.REP_W(REP_W)) u_rep (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrap      (ovf || unf),
    .force_upd (force_upd),
    .rep_val   (rep_q),
    .upd       (upd)
  );

  assign upd_evt  = evt_q;
  assign upd_flag = flag_q;
  assign cmp_act  = cmp_act_q;

  // R10: the flag is high whenever the update pulse is
  a_r10_flag_with_evt: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> flag_q);

  // R8: with preload on, the active limit holds between updates
  a_r8_arr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (arpe_q && !upd) |=> (arr_act_q == $past(arr_act_q)));

  // R7: active compare values move only on an update
  a_r7_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(cmp_act_q));

  // R9: a forced update always yields the pulse one cycle later
  a_r9_force_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> evt_q);

endmodule

// File: tb/rep_gated_timebase_bench.sv
`timescale 1ns/1ps
module rep_gated_timebase_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic        slave_trig;
  logic        upd_evt, upd_flag;
  logic [15:0] cnt_val;
  logic [31:0] cmp_act;

  always #2.5 clk = ~clk;

  rep_gated_timebase u_rep_gated_timebase (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .slave_trig(slave_trig), .upd_evt(upd_evt), .upd_flag(upd_flag),
    .cnt_val(cnt_val), .cmp_act(cmp_act)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_en, m_mode, m_arpe, m_psc_pre, m_psc, m_arr_pre, m_arr, m_rep_reg, m_rep;
  int m_pc, m_cnt, m_dn, m_evt, m_flag;
  int m_cmp_pre [2];
  int m_cmp [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_arpe = 0; m_psc_pre = 0; m_psc = 0;
      m_arr_pre = 65535; m_arr = 65535; m_rep_reg = 0; m_rep = 0;
      m_pc = 0; m_cnt = 0; m_dn = 0; m_evt = 0; m_flag = 0;
      for (int i = 0; i < 2; i++) begin m_cmp_pre[i] = 0; m_cmp[i] = 0; end
    end else begin
      int md, arr_nx;
      bit frc, tk, ov, un, upd;
      frc = (wr_en && wr_addr == 1 && wr_data[0]) || slave_trig;
      md  = (m_mode == 3) ? 2 : m_mode;
      tk  = (m_en != 0) && (m_pc >= m_psc);
      ov = 0; un = 0;
      if (!frc && tk) begin
        if (md == 0)      ov = (m_cnt >= m_arr);
        else if (md == 1) un = (m_cnt == 0);
        else if (m_dn == 0) ov = (m_cnt >= m_arr);
        else              un = (m_cnt == 0);
      end
      upd = frc || ((ov || un) && m_rep == 0);
      if (m_arpe == 0 && wr_en && wr_addr == 4) arr_nx = wr_data;
      else if (upd) arr_nx = m_arr_pre;
      else arr_nx = m_arr;
      if (frc) begin
        m_cnt = (md == 1) ? arr_nx : 0; m_dn = 0;
      end else if (tk) begin
        if (md == 0) begin m_dn = 0; m_cnt = ov ? 0 : m_cnt + 1; end
        else if (md == 1) begin m_dn = 0; m_cnt = un ? arr_nx : m_cnt - 1; end
        else if (m_dn == 0) begin
          if (ov) begin m_cnt = (m_arr == 0) ? 0 : m_arr - 1; m_dn = 1; end
          else m_cnt = m_cnt + 1;
        end else begin
          if (un) begin m_cnt = (m_arr == 0) ? 0 : 1; m_dn = 0; end
          else m_cnt = m_cnt - 1;
        end
      end
      if (frc) m_pc = 0;
      else if (m_en != 0) m_pc = tk ? 0 : m_pc + 1;
      if (upd) m_rep = m_rep_reg;
      else if (ov || un) m_rep = m_rep - 1;
      if (upd) begin
        m_psc = m_psc_pre;
        for (int i = 0; i < 2; i++) m_cmp[i] = m_cmp_pre[i];
      end
      m_arr = arr_nx;
      if (upd) m_flag = 1;
      else if (wr_en && wr_addr == 2 && !wr_data[0]) m_flag = 0;
      m_evt = upd;
      if (wr_en) begin
        case (wr_addr)
          4'd0: begin m_en = wr_data[0]; m_mode = wr_data[2:1]; m_arpe = wr_data[3]; end
          4'd3: m_psc_pre = wr_data;
          4'd4: m_arr_pre = wr_data;
          4'd5: m_rep_reg = wr_data[7:0];
          4'd6: m_cmp_pre[0] = wr_data;
          4'd7: m_cmp_pre[1] = wr_data;
          default: ;
        endcase
      end
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk(cnt_val == 16'(m_cnt), "R3 counter value vs model", cnt_val, m_cnt);
      chk(upd_evt == m_evt[0], "R5 update pulse vs model", upd_evt, m_evt);
      chk(upd_flag == m_flag[0], "R10 update flag vs model", upd_flag, m_flag);
      for (int i = 0; i < 2; i++)
        chk(cmp_act[i*16 +: 16] == 16'(m_cmp[i]), "R7 active compare vs model",
            cmp_act[i*16 +: 16], m_cmp[i]);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic trig();
    @(negedge clk);
    slave_trig = 1'b1;
    @(posedge clk); #1;
    slave_trig = 1'b0;
  endtask

  task automatic count_upd(input int n, output int c);
    @(negedge clk);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (upd_evt) c++;
    end
  endtask

  task automatic track_max(output int mx);
    mx = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (upd_evt) break;
      if (int'(cnt_val) > mx) mx = int'(cnt_val);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int c, mx;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; slave_trig = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cnt_val == 0, "R1 counter after reset", cnt_val, 0);
    chk(upd_flag == 0, "R1 flag after reset", upd_flag, 0);
    chk(upd_evt == 0, "R1 pulse after reset", upd_evt, 0);
    chk(cmp_act == 0, "R1 compares after reset", cmp_act, 0);

    // R2 prescaler of 2
    wr(3, 2); wr(4, 5); wr(5, 0); wr(0, 1);
    trig();
    @(negedge clk);
    chk(upd_evt == 1, "R9 trigger gives pulse", upd_evt, 1);
    chk(cnt_val == 0, "R9 trigger restarts counter", cnt_val, 0);
    repeat (2) @(negedge clk);
    chk(cnt_val == 0, "R2 no step before P+1 clocks", cnt_val, 0);
    @(negedge clk);
    chk(cnt_val == 1, "R2 step after P+1 clocks", cnt_val, 1);

    // R5 up mode, N=2, L=3
    wr(3, 0); wr(4, 3); wr(5, 2); wr(0, 1);
    trig(); count_upd(80, c);
    chk(c == 6, "R5 up mode one update per 3 wraps", c, 6);

    // R6 down mode, N=0, L=3
    wr(5, 0); wr(0, 3);
    trig(); count_upd(80, c);
    chk(c == 20, "R6 down mode underflow decrement", c, 20);

    // R6 center mode, N=1, L=4
    wr(4, 4); wr(5, 1); wr(0, 5);
    trig(); count_upd(80, c);
    chk(c == 9, "R6 center mode both-edge decrement", c, 9);

    // R8 limit preload on, then off
    wr(0, 9); wr(4, 10); wr(5, 0);
    trig();
    @(negedge clk);
    repeat (3) @(negedge clk);
    wr(4, 20);
    track_max(mx);
    chk(mx == 10, "R8 preloaded write keeps old limit", mx, 10);
    track_max(mx);
    chk(mx == 20, "R8 new limit after update", mx, 20);
    wr(0, 1);
    repeat (2) @(negedge clk);
    wr(4, 6);
    track_max(mx);
    chk(mx == 6, "R8 direct write acts at once", mx, 6);

    // R7 compare shadows
    wr(0, 0);
    wr(6, 16'h1234); wr(7, 16'hBEEF);
    @(negedge clk);
    chk(cmp_act[15:0] == 16'h0000, "R7 compare 0 held before update", cmp_act[15:0], 0);
    chk(cmp_act[31:16] == 16'h0000, "R7 compare 1 held before update", cmp_act[31:16], 0);
    wr(1, 1);
    @(negedge clk);
    chk(upd_evt == 1, "R9 event write gives pulse", upd_evt, 1);
    chk(cmp_act[15:0] == 16'h1234, "R7 compare 0 loaded", cmp_act[15:0], 16'h1234);
    chk(cmp_act[31:16] == 16'hBEEF, "R7 compare 1 loaded", cmp_act[31:16], 16'hBEEF);

    // R10 flag clear rules
    wr(2, 1);
    @(negedge clk);
    chk(upd_flag == 1, "R10 status write of 1 ignored", upd_flag, 1);
    wr(2, 0);
    @(negedge clk);
    chk(upd_flag == 0, "R10 status write of 0 clears", upd_flag, 0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd2; wr_data = 16'd0; slave_trig = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; slave_trig = 1'b0;
    @(negedge clk);
    chk(upd_flag == 1, "R10 set wins over clear", upd_flag, 1);

    // mixed random stimulus against the model (R3 R4 R5 R6 R7 R8 R9 R10)
    wr(4, 5); wr(3, 1); wr(5, 1); wr(0, 13);
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      wr_en = ($urandom % 4) == 0;
      wr_addr = 4'($urandom % 8);
      wr_data = (wr_addr == 4'd0) ? 16'($urandom & 15) : 16'($urandom & 7);
      slave_trig = ($urandom % 60) == 0;
    end
    @(negedge clk);
    wr_en = 1'b0; slave_trig = 1'b0;
    repeat (20) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule